// File: doc/BRIEF.md
# Write-Through Direct-Mapped Cache with Mode Control

This block is a direct-mapped cache placed between a processor port that moves one word per request and a memory port that returns a whole block on a read. Each request address is cut into three fields. The upper bits form the tag. The middle bits pick a cache line. The low bits pick a word inside the line. The line picked by the address is read out, and its stored tag is compared with the tag of the request. Hits are served from the cache. Misses go to memory. Writes follow a write-through, no-allocate policy.

Two configuration inputs choose the operating mode. The mode controls three things: whether read misses load the cache, whether write hits are copied to memory, and whether line invalidation requests take effect. One combination of the two inputs is not allowed. The block reports it on an error output and then runs with all three features turned off.

The processor port uses a valid/ready request. A response strobe is returned once per accepted request. The memory port has a block-read request and a single-word write request. Each is held until the memory acknowledges it.

Top module: `wt_dm_cache`

## Requirements
- R1: The address is split as tag = `req_addr[ADDR_W-1 : LINE_BITS+WORD_BITS]`, line = `req_addr[LINE_BITS+WORD_BITS-1 : WORD_BITS]`, word = `req_addr[WORD_BITS-1:0]`. A read hits only when the indexed line is valid and its stored tag equals the request tag. A block with a different tag on the same line replaces the previous occupant.
- R2: A read hit raises `rsp_valid` for one cycle, in the cycle after the clock edge that accepted the request, with the stored word on `rsp_rdata`. It issues no memory request.
- R3: A read miss with fills enabled issues one `mem_rd_req` for block address `req_addr[ADDR_W-1:WORD_BITS]`. Word i of the block is carried in `mem_rd_block[i*WORD_W +: WORD_W]`. The block and its tag are loaded into the indexed line, and the requested word is returned.
- R4: A read miss with fills disabled returns the word from memory and leaves every cache line unchanged, so a repeat of the same read misses again.
- R5: A write hit updates the addressed word in the cache. With write-through enabled it also issues one `mem_wr_req` carrying the full word address and data.
- R6: A write miss always issues one `mem_wr_req` and allocates no line, so a later read of that block misses.
- R7: With write-through disabled, a write hit updates only the cache and issues no memory write.
- R8: With `cfg_fill_off`=0 and `cfg_wt_off`=0, fills, write-throughs and invalidations are all enabled. With `cfg_fill_off`=1 and `cfg_wt_off`=0, only fills are disabled. With both inputs at 1, all three are disabled.
- R9: With `cfg_fill_off`=0 and `cfg_wt_off`=1, `cfg_illegal` is 1, and in every other case it is 0. In this illegal state fills, write-throughs and invalidations are all disabled.
- R10: `inv_valid` clears the valid bit of line `inv_line` only when invalidations are enabled. Otherwise it has no effect, and a later read of the resident block still hits. If an invalidation and a fill target the same line in the same cycle, the invalidation wins.
- R11: A synchronous active-low reset clears every valid bit and leaves `req_ready`=1 and `rsp_valid`=0. The first read after reset misses.
- R12: `mem_rd_req` and `mem_wr_req` stay high, with stable address and data, until the matching acknowledge. No new request is accepted while either one is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fill_off | input | 1 | Mode bit: suppresses line fills |
| cfg_wt_off | input | 1 | Mode bit: suppresses write-through and invalidation |
| cfg_illegal | output | 1 | High while the mode bits are in the forbidden combination |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | WORD_W | Read data (zero for writes) |
| inv_valid | input | 1 | Line invalidation request |
| inv_line | input | LINE_BITS | Line to invalidate |
| mem_rd_req | output | 1 | Block read request |
| mem_rd_addr | output | ADDR_W-WORD_BITS | Block address |
| mem_rd_ack | input | 1 | Block read data valid |
| mem_rd_block | input | WORD_W<<WORD_BITS | Block contents, word 0 in the low bits |
| mem_wr_req | output | 1 | Word write request |
| mem_wr_addr | output | ADDR_W | Word write address |
| mem_wr_data | output | WORD_W | Word write data |
| mem_wr_ack | input | 1 | Word write accepted |

## Verification
The bench builds the cache with an 8-bit address, 2 line bits and 2 word bits. That gives four lines of four 8-bit words and a 4-bit tag. With so few lines, two tags on the same line can be made to evict each other in a handful of requests, and an invalidation can be aimed at a known line. The small address space lets the bench keep a full image of memory. Every fill, write-through and bypassed read can then be predicted under each of the four mode combinations, including the switch from a filled line into the modes that freeze it.

// File: rtl/dmc_pkg.sv
// Shared types for the write-through direct-mapped cache.
// Assumes: none beyond a synthesizable SystemVerilog flow.
package dmc_pkg;

    // Feature enables decoded from the two mode inputs
    typedef struct packed {
        logic fill_en;
        logic wt_en;
        logic inv_en;
        logic bad;
    } dmc_mode_t;

    // Request sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_RSP  = 2'd3
    } dmc_state_t;

endpackage

// File: rtl/dmc_mode_dec.sv
// Turns the two mode inputs into feature enables.
// Assumes: the forbidden combination (fill_off=0, wt_off=1) runs with
// every feature disabled, while the error flag reports it.
module dmc_mode_dec
    import dmc_pkg::*;
(
    input  logic      fill_off,
    input  logic      wt_off,
    output dmc_mode_t mode
);

    // Decode the mode table
    always_comb begin
        mode.bad     = !fill_off && wt_off;
        mode.fill_en = !fill_off && !wt_off;
        mode.wt_en   = !wt_off;
        mode.inv_en  = !wt_off;
    end

endmodule

// File: rtl/dmc_line_store.sv
// Holds the tag, data and valid bit of every cache line.
// Assumes: at most one of fill/update per cycle (the sequencer guarantees
// it). The valid bits reset synchronously, tags and data are not reset.
// An invalidation overrides a fill of the same line in the same cycle.
module dmc_line_store #(
    parameter int LINE_BITS = 8,
    parameter int TAG_W     = 14,
    parameter int WORD_BITS = 2,
    parameter int WORD_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINE_BITS-1:0] lk_idx,
    output logic                 lk_valid,
    output logic [TAG_W-1:0]     lk_tag,
    output logic [(WORD_W<<WORD_BITS)-1:0] lk_block,
    input  logic                 fill_we,
    input  logic [LINE_BITS-1:0] fill_idx,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic [(WORD_W<<WORD_BITS)-1:0] fill_block,
    input  logic                 upd_we,
    input  logic [LINE_BITS-1:0] upd_idx,
    input  logic [WORD_BITS-1:0] upd_word,
    input  logic [WORD_W-1:0]    upd_data,
    input  logic                 clr_we,
    input  logic [LINE_BITS-1:0] clr_idx
);

    localparam int LINES = 1 << LINE_BITS;
    localparam int WORDS = 1 << WORD_BITS;
    localparam int BLK_W = WORD_W * WORDS;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [BLK_W-1:0] blk_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [BLK_W-1:0] upd_blk;

    // One lane per word: keep the stored word or take the write data
    for (genvar g = 0; g < WORDS; g++) begin : g_lane
        assign upd_blk[g*WORD_W +: WORD_W] =
            (upd_word == WORD_BITS'(g)) ? upd_data : blk_q[upd_idx][g*WORD_W +: WORD_W];
    end

    // Combinational lookup of the indexed line
    assign lk_valid = valid_q[lk_idx];
    assign lk_tag   = tag_q[lk_idx];
    assign lk_block = blk_q[lk_idx];

    // Tag and data storage: fill a whole line or patch one word
    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_q[fill_idx] <= fill_tag;
            blk_q[fill_idx] <= fill_block;
        end else if (upd_we) begin
            blk_q[upd_idx] <= upd_blk;
        end
    end

    // Valid bits: cleared by reset, set by fill, cleared by invalidation last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (fill_we) valid_q[fill_idx] <= 1'b1;
            if (clr_we)  valid_q[clr_idx]  <= 1'b0;
        end
    end

    // R10
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> !valid_q[$past(clr_idx)]);

    // R3
    fill_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_we && !(clr_we && clr_idx == fill_idx)) |=> valid_q[$past(fill_idx)]);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> valid_q == '0);

endmodule

// File: rtl/dmc_ctrl.sv
// Request sequencer: accepts one processor request at a time, resolves
// hit or miss against the line store, runs the memory transfer the mode
// calls for and returns a one-cycle response.
// Assumes: the memory holds acknowledges for one cycle per request.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int LINE_BITS = 8,
    parameter int WORD_BITS = 2,
    parameter int WORD_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  dmc_mode_t            mode,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_rdata,
    output logic [LINE_BITS-1:0] lk_idx,
    input  logic                 lk_valid,
    input  logic [ADDR_W-LINE_BITS-WORD_BITS-1:0] lk_tag,
    input  logic [(WORD_W<<WORD_BITS)-1:0] lk_block,
    output logic                 fill_we,
    output logic [LINE_BITS-1:0] fill_idx,
    output logic [ADDR_W-LINE_BITS-WORD_BITS-1:0] fill_tag,
    output logic                 upd_we,
    output logic [LINE_BITS-1:0] upd_idx,
    output logic [WORD_BITS-1:0] upd_word,
    output logic [WORD_W-1:0]    upd_data,
    output logic                 mem_rd_req,
    output logic [ADDR_W-WORD_BITS-1:0] mem_rd_addr,
    input  logic                 mem_rd_ack,
    input  logic [(WORD_W<<WORD_BITS)-1:0] mem_rd_block,
    output logic                 mem_wr_req,
    output logic [ADDR_W-1:0]    mem_wr_addr,
    output logic [WORD_W-1:0]    mem_wr_data,
    input  logic                 mem_wr_ack
);

    localparam int TAG_W  = ADDR_W - LINE_BITS - WORD_BITS;
    localparam int TAG_LO = LINE_BITS + WORD_BITS;

    dmc_state_t           st_q, st_d;
    logic [ADDR_W-1:0]    addr_q;
    logic [WORD_W-1:0]    wdata_q;
    logic [WORD_W-1:0]    rdata_q, rdata_d;
    logic                 hit;
    logic                 accept;

    // Field views of the incoming and the held address
    logic [TAG_W-1:0]     req_tag;
    logic [LINE_BITS-1:0] req_line;
    logic [WORD_BITS-1:0] req_word;
    logic [WORD_BITS-1:0] q_word;

    assign req_tag  = req_addr[ADDR_W-1:TAG_LO];
    assign req_line = req_addr[WORD_BITS +: LINE_BITS];
    assign req_word = req_addr[WORD_BITS-1:0];
    assign q_word   = addr_q[WORD_BITS-1:0];

    // Tag compare against the line picked by the incoming address
    assign lk_idx = req_line;
    assign hit    = lk_valid && (lk_tag == req_tag);

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

    // Next state, memory strobes and line store writes
    always_comb begin
        st_d     = st_q;
        rdata_d  = rdata_q;
        upd_we   = 1'b0;
        fill_we  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        upd_we  = hit;
                        rdata_d = '0;
                        st_d    = (!hit || mode.wt_en) ? ST_WR : ST_RSP;
                    end else if (hit) begin
                        rdata_d = lk_block[req_word*WORD_W +: WORD_W];
                        st_d    = ST_RSP;
                    end else begin
                        st_d = ST_RD;
                    end
                end
            end
            ST_RD: begin
                if (mem_rd_ack) begin
                    fill_we = mode.fill_en;
                    rdata_d = mem_rd_block[q_word*WORD_W +: WORD_W];
                    st_d    = ST_RSP;
                end
            end
            ST_WR: begin
                if (mem_wr_ack) st_d = ST_RSP;
            end
            ST_RSP: begin
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Write and fill targets
    assign upd_idx  = req_line;
    assign upd_word = req_word;
    assign upd_data = req_wdata;
    assign fill_idx = addr_q[WORD_BITS +: LINE_BITS];
    assign fill_tag = addr_q[ADDR_W-1:TAG_LO];

    // Memory and response outputs straight from held state
    assign mem_rd_req  = (st_q == ST_RD);
    assign mem_rd_addr = addr_q[ADDR_W-1:WORD_BITS];
    assign mem_wr_req  = (st_q == ST_WR);
    assign mem_wr_addr = addr_q;
    assign mem_wr_data = wdata_q;
    assign rsp_valid   = (st_q == ST_RSP);
    assign rsp_rdata   = rdata_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Request capture and read data holding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            rdata_q <= rdata_d;
        end
    end

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R12
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R12
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |-> !req_ready);

    // R2
    hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_write && hit) |=> (rsp_valid && !mem_rd_req));

    // R2
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: rtl/wt_dm_cache.sv
// Top level of the write-through direct-mapped cache: mode decoder,
// line store and request sequencer.
// Assumes: one outstanding processor request; memory acknowledges each
// request with a single-cycle pulse.
module wt_dm_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int LINE_BITS = 8,
    parameter int WORD_BITS = 2,
    parameter int WORD_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_fill_off,
    input  logic                 cfg_wt_off,
    output logic                 cfg_illegal,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [WORD_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_rdata,
    input  logic                 inv_valid,
    input  logic [LINE_BITS-1:0] inv_line,
    output logic                 mem_rd_req,
    output logic [ADDR_W-WORD_BITS-1:0] mem_rd_addr,
    input  logic                 mem_rd_ack,
    input  logic [(WORD_W<<WORD_BITS)-1:0] mem_rd_block,
    output logic                 mem_wr_req,
    output logic [ADDR_W-1:0]    mem_wr_addr,
    output logic [WORD_W-1:0]    mem_wr_data,
    input  logic                 mem_wr_ack
);

    localparam int TAG_W = ADDR_W - LINE_BITS - WORD_BITS;
    localparam int BLK_W = WORD_W << WORD_BITS;

    dmc_mode_t            mode;
    logic [LINE_BITS-1:0] lk_idx, fill_idx, upd_idx;
    logic                 lk_valid, fill_we, upd_we, clr_we;
    logic [TAG_W-1:0]     lk_tag, fill_tag;
    logic [BLK_W-1:0]     lk_block;
    logic [WORD_BITS-1:0] upd_word;
    logic [WORD_W-1:0]    upd_data;

    dmc_mode_dec u_mode (
        .fill_off (cfg_fill_off),
        .wt_off   (cfg_wt_off),
        .mode     (mode)
    );

    assign cfg_illegal = mode.bad;

    // Invalidation honoured only when the mode allows it
    assign clr_we = inv_valid && mode.inv_en;

    dmc_line_store #(
        .LINE_BITS (LINE_BITS),
        .TAG_W     (TAG_W),
        .WORD_BITS (WORD_BITS),
        .WORD_W    (WORD_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (lk_idx),
        .lk_valid   (lk_valid),
        .lk_tag     (lk_tag),
        .lk_block   (lk_block),
        .fill_we    (fill_we),
        .fill_idx   (fill_idx),
        .fill_tag   (fill_tag),
        .fill_block (mem_rd_block),
        .upd_we     (upd_we),
        .upd_idx    (upd_idx),
        .upd_word   (upd_word),
        .upd_data   (upd_data),
        .clr_we     (clr_we),
        .clr_idx    (inv_line)
    );

    dmc_ctrl #(
        .ADDR_W    (ADDR_W),
        .LINE_BITS (LINE_BITS),
        .WORD_BITS (WORD_BITS),
        .WORD_W    (WORD_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .lk_idx       (lk_idx),
        .lk_valid     (lk_valid),
        .lk_tag       (lk_tag),
        .lk_block     (lk_block),
        .fill_we      (fill_we),
        .fill_idx     (fill_idx),
        .fill_tag     (fill_tag),
        .upd_we       (upd_we),
        .upd_idx      (upd_idx),
        .upd_word     (upd_word),
        .upd_data     (upd_data),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_ack   (mem_rd_ack),
        .mem_rd_block (mem_rd_block),
        .mem_wr_req   (mem_wr_req),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_ack   (mem_wr_ack)
    );

    // R9
    illegal_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_illegal |-> (!fill_we && !clr_we));

    // R8
    fill_only_when_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> (!cfg_fill_off && mem_rd_ack));

endmodule

// File: tb/test_wt_dm_cache.sv
// Self-checking bench: behavioural cache and memory model compared
// against the design on every transaction and every clock.
module test_wt_dm_cache;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 8;
    localparam int LB  = 2;
    localparam int WB  = 2;
    localparam int WW  = 8;
    localparam int NL  = 1 << LB;
    localparam int NW  = 1 << WB;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_fill_off = 1'b0, cfg_wt_off = 1'b0;
    logic cfg_illegal;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [WW-1:0] req_wdata = '0;
    logic rsp_valid;
    logic [WW-1:0] rsp_rdata;
    logic inv_valid = 1'b0;
    logic [LB-1:0] inv_line = '0;
    logic mem_rd_req, mem_wr_req;
    logic [AW-WB-1:0] mem_rd_addr;
    logic mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
    logic [WW*NW-1:0] mem_rd_block = '0;
    logic [AW-1:0] mem_wr_addr;
    logic [WW-1:0] mem_wr_data;

    int total = 0, bad = 0;
    int rd_cnt = 0, wr_cnt = 0;
    int wr_last_a = 0, wr_last_d = 0;
    bit done = 0, in_req = 0;

    // Behavioural model state
    logic [WW-1:0] bmem [256];
    bit mv [NL];
    int mt [NL];
    int md [NL][NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_dm_cache #(.ADDR_W(AW), .LINE_BITS(LB), .WORD_BITS(WB), .WORD_W(WW)) i_wt_dm_cache (
        .clk(clk), .rst_n(rst_n), .cfg_fill_off(cfg_fill_off), .cfg_wt_off(cfg_wt_off),
        .cfg_illegal(cfg_illegal), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .inv_valid(inv_valid),
        .inv_line(inv_line), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_block(mem_rd_block), .mem_wr_req(mem_wr_req),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
        end
    endtask

    function automatic bit m_fill(); return !cfg_fill_off && !cfg_wt_off; endfunction
    function automatic bit m_wt();   return !cfg_wt_off; endfunction

    // Memory responder: fixed latency, checks request stability (R12)
    initial begin
        int rw = 0, ww = 0;
        bit rseen = 0, wseen = 0;
        int ra = 0, wa = 0, wd = 0;
        forever begin
            @(negedge clk);
            if (mem_rd_ack) mem_rd_ack = 1'b0;
            else if (mem_rd_req) begin
                if (rseen) chk(mem_rd_addr == ra[AW-WB-1:0], "R12 rd addr stable", mem_rd_addr, ra);
                rseen = 1; ra = mem_rd_addr; rw++;
                if (rw == LAT) begin
                    for (int k = 0; k < NW; k++)
                        mem_rd_block[k*WW +: WW] = bmem[{mem_rd_addr, WB'(k)}];
                    mem_rd_ack = 1'b1; rd_cnt++; rw = 0; rseen = 0;
                end
            end
            if (mem_wr_ack) mem_wr_ack = 1'b0;
            else if (mem_wr_req) begin
                if (wseen) chk(mem_wr_addr == wa[AW-1:0] && mem_wr_data == wd[WW-1:0],
                               "R12 wr stable", {mem_wr_addr, mem_wr_data}, {wa[7:0], wd[7:0]});
                wseen = 1; wa = mem_wr_addr; wd = mem_wr_data; ww++;
                if (ww == LAT) begin
                    bmem[mem_wr_addr] = mem_wr_data;
                    wr_last_a = mem_wr_addr; wr_last_d = mem_wr_data;
                    mem_wr_ack = 1'b1; wr_cnt++; ww = 0; wseen = 0;
                end
            end
        end
    end

    // Per-clock comparison of error flag and unexpected responses
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(cfg_illegal == (!cfg_fill_off && cfg_wt_off), "R9 illegal flag",
                    cfg_illegal, (!cfg_fill_off && cfg_wt_off));
                if (!in_req) chk(!rsp_valid, "R2 stray response", rsp_valid, 0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_req(input bit wr, input int a, input int d, input string rq);
        int t = a >> (LB + WB);
        int l = (a >> WB) % NL;
        int w = a % NW;
        bit hit = mv[l] && mt[l] == t;
        int exp_rd = (!wr && !hit) ? 1 : 0;
        int exp_wr = (wr && (!hit || m_wt())) ? 1 : 0;
        int exp_d = wr ? 0 : (hit ? md[l][w] : int'(bmem[a]));
        int rd0 = rd_cnt, wr0 = wr_cnt, n = 0;
        if (wr && hit) md[l][w] = d;
        if (!wr && !hit && m_fill()) begin
            mv[l] = 1; mt[l] = t;
            for (int k = 0; k < NW; k++) md[l][k] = bmem[(a & ~(NW-1)) + k];
        end
        @(negedge clk);
        in_req = 1;
        req_valid = 1'b1; req_write = wr; req_addr = a[AW-1:0]; req_wdata = d[WW-1:0];
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
        chk(rsp_valid, {rq, " response"}, rsp_valid, 1);
        if (!wr) chk(rsp_rdata == exp_d[WW-1:0], {rq, " read data"}, rsp_rdata, exp_d);
        if (!wr && hit) chk(n == 0, {rq, " hit latency"}, n, 0);
        chk(rd_cnt - rd0 == exp_rd, {rq, " block reads"}, rd_cnt - rd0, exp_rd);
        chk(wr_cnt - wr0 == exp_wr, {rq, " word writes"}, wr_cnt - wr0, exp_wr);
        if (exp_wr == 1)
            chk(wr_last_a == a && wr_last_d == d, {rq, " write content"},
                (wr_last_a << 8) | wr_last_d, (a << 8) | d);
        in_req = 0;
    endtask

    task automatic do_inv(input int l);
        @(negedge clk);
        inv_valid = 1'b1; inv_line = l[LB-1:0];
        @(negedge clk);
        inv_valid = 1'b0;
        if (!cfg_wt_off) mv[l] = 0;
    endtask

    task automatic set_mode(input bit fo, input bit wo);
        @(negedge clk);
        cfg_fill_off = fo; cfg_wt_off = wo;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NL; i++) mv[i] = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'((i * 7 + 3) ^ 8'h5A);
        for (int i = 0; i < NL; i++) mv[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R11 no response after reset", rsp_valid, 0);
        chk(!mem_rd_req && !mem_wr_req, "R11 memory idle", {mem_rd_req, mem_wr_req}, 0);

        // R8 mode 00: everything enabled
        do_req(0, 8'h10, 0, "R3 miss fill");
        do_req(0, 8'h13, 0, "R2 hit");
        do_req(0, 8'h50, 0, "R1 alias evicts");
        do_req(0, 8'h11, 0, "R1 evicted misses");
        do_req(1, 8'h12, 8'hAA, "R5 write hit");
        do_req(0, 8'h12, 0, "R5 readback");
        do_req(1, 8'h24, 8'h3C, "R6 write miss");
        do_req(0, 8'h25, 0, "R6 no allocate");
        do_inv(0);
        do_req(0, 8'h11, 0, "R10 invalidated misses");

        // R8 mode 10: no fills
        set_mode(1, 0);
        do_req(0, 8'h38, 0, "R4 bypass read");
        do_req(0, 8'h38, 0, "R4 still misses");
        do_req(0, 8'h25, 0, "R8 resident hit");
        do_inv(1);
        do_req(0, 8'h25, 0, "R10 honoured in no-fill mode");
        do_req(1, 8'h11, 8'h77, "R8 write-through on");

        // R7 mode 11: nothing enabled
        set_mode(0, 0);
        do_req(0, 8'h2C, 0, "R3 fill line 3");
        set_mode(1, 1);
        do_req(1, 8'h2D, 8'h55, "R7 write hit no wt");
        do_req(0, 8'h2D, 0, "R7 cache updated");
        do_inv(3);
        do_req(0, 8'h2E, 0, "R10 ignored");
        do_req(1, 8'h60, 8'h99, "R6 write miss no wt");

        // R9 illegal combination
        set_mode(0, 1);
        @(negedge clk);
        chk(cfg_illegal == 1'b1, "R9 flag raised", cfg_illegal, 1);
        do_req(0, 8'h39, 0, "R9 no fill");
        do_req(0, 8'h39, 0, "R9 still misses");
        do_inv(3);
        do_req(0, 8'h2F, 0, "R9 invalidate ignored");
        do_req(1, 8'h2C, 8'h42, "R9 no write-through");

        // R11 second reset drops all lines
        set_mode(0, 0);
        do_reset();
        do_req(0, 8'h2C, 0, "R11 miss after reset");
        do_req(0, 8'h2C, 0, "R11 refilled hit");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule